// File: doc/BRIEF.md
# Sum-Addressed Word-Line Decoder

This block selects one of 2^N memory rows whose index is the sum of a base and an offset, as happens when a cache set index is formed from a register value plus a displacement. No adder is built. Each word line has its own small comparator that asks one question: could this line's fixed index be the sum of the two operands? It answers bit by bit with carry-consistency logic that has no carry chain. Exactly one line satisfies the test, and that line goes high.

The per-bit terms that do not depend on the line index are the propagate (XOR) and generate (AND) of the two operands. They are formed once and shared by every comparator. Each comparator then works out the carry-in that each bit would need for its index to be the sum. It also works out the carry-out that the bit would produce with that carry-in. The comparator requires the two to agree between neighbouring bits. The carry out of the top bit is dropped, so the sum wraps modulo 2^N. An enable input gates all lines. A parameter either registers the word-line vector, with one cycle of latency, or leaves the path purely combinational.

Top module: `sum_addr_decoder`

## Requirements
- R1: With enable high, the only word line driven high is the one whose index is (base + offset) mod 2^ADDR_W. Bit j of word_line is line j. When REG_OUT=1 the line appears one clock after the operands are sampled.
- R2: With enable high, exactly one bit of word_line is 1.
- R3: With enable low, every bit of word_line is 0 (one clock later when REG_OUT=1), whatever base and offset are.
- R4: When base + offset is 2^ADDR_W or more, the selected line is base + offset - 2^ADDR_W. The carry out of the top bit is discarded.
- R5: When REG_OUT=1, word_line is all zeros while rst_n is low and stays zero until the first capture after release.
- R6: An offset of zero selects line base, and a base of zero selects line offset.
- R7: Swapping base and offset selects the same line.
- R8: When REG_OUT=0, word_line follows base, offset and enable in the same cycle, with no register, and obeys R1 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High lets the selected line assert; low forces all lines low |
| base | input | ADDR_W | Base operand of the row address |
| offset | input | ADDR_W | Offset operand of the row address |
| word_line | output | 2**ADDR_W | One-hot row select, bit j is line j |

## Verification
The bench sweeps every base and offset pair. It does this on a registered 4-bit instance and on a combinational 3-bit instance, and compares each output against the sum of the two operands reduced modulo the line count. Wrapping sums are the main target. A comparator that honoured the top carry-out, or that let bit 0 accept a carry-in, would leave no line high or would raise a wrong line. The bench also checks zero operands, swapped operands and a disabled decoder. A bad enable gate would leave a stale line high, and a missing register would show the new line one cycle early.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Carry a bit must receive for its sum bit to equal k.
  function automatic logic need_cin(input logic prop, input logic k);
    return prop ^ k;
  endfunction

  // Carry a bit emits once it receives the carry it needs.
  function automatic logic make_cout(input logic prop, input logic gen, input logic k);
    return gen | (prop & ~k);
  endfunction

endpackage

// File: rtl/sad_pair_terms.sv
module sad_pair_terms #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] prop,
  output logic [ADDR_W-1:0] gen
);

  always_comb begin
    prop = base ^ offset;
    gen  = base & offset;
  end

endmodule

// File: rtl/sad_line_cmp.sv
module sad_line_cmp
  import sad_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int LINE_IDX = 0
) (
  input  logic [ADDR_W-1:0] prop,
  input  logic [ADDR_W-1:0] gen,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] KIDX = LINE_IDX[ADDR_W-1:0];

  logic [ADDR_W-1:0] cin_need;
  logic [ADDR_W-2:0] cout_made;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      cin_need[i] = need_cin(prop[i], KIDX[i]);
    end
    for (int i = 0; i < ADDR_W - 1; i++) begin
      cout_made[i] = make_cout(prop[i], gen[i], KIDX[i]);
    end
  end

  always_comb begin
    hit = ~cin_need[0];
    for (int i = 1; i < ADDR_W; i++) begin
      hit = hit & ~(cout_made[i-1] ^ cin_need[i]);
    end
  end

endmodule

// File: rtl/sad_wl_stage.sv
module sad_wl_stage #(
  parameter int LINES   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LINES-1:0] hits,
  output logic [LINES-1:0] word_line
);

  logic [LINES-1:0] wl_next;

  always_comb begin
    wl_next = enable ? hits : '0;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [LINES-1:0] wl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wl_q <= '0;
        end else begin
          wl_q <= wl_next;
        end
      end
      assign word_line = wl_q;
    end else begin : g_comb
      assign word_line = wl_next;
    end
  endgenerate

endmodule

// File: rtl/sum_addr_decoder.sv
module sum_addr_decoder #(
  parameter int ADDR_W  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [ADDR_W-1:0]    base,
  input  logic [ADDR_W-1:0]    offset,
  output logic [2**ADDR_W-1:0] word_line
);

  localparam int LINES = 2 ** ADDR_W;

  logic [ADDR_W-1:0] prop;
  logic [ADDR_W-1:0] gen;
  logic [LINES-1:0]  hits;

  sad_pair_terms #(.ADDR_W(ADDR_W)) u_terms (
    .base   (base),
    .offset (offset),
    .prop   (prop),
    .gen    (gen)
  );

  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      sad_line_cmp #(.ADDR_W(ADDR_W), .LINE_IDX(l)) u_cmp (
        .prop (prop),
        .gen  (gen),
        .hit  (hits[l])
      );
    end
  endgenerate

  sad_wl_stage #(.LINES(LINES), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .hits      (hits),
    .word_line (word_line)
  );

endmodule

// File: rtl/sad_chk.sv
module sad_chk #(
  parameter int ADDR_W  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic [ADDR_W-1:0]    base,
  input logic [ADDR_W-1:0]    offset,
  input logic [2**ADDR_W-1:0] word_line
);

  generate
    if (REG_OUT) begin : g_reg
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
      end

      AST_LINE_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enable)) |-> word_line[ADDR_W'($past(base) + $past(offset))]); // R1
      AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enable)) |-> ($countones(word_line) == 1)); // R2
      AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(enable)) |-> (word_line == '0)); // R3
      AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enable) && ($past(offset) == '0)) |-> word_line[$past(base)]); // R6
    end else begin : g_comb
      AST_LINE_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> word_line[ADDR_W'(base + offset)]); // R8
      AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ($countones(word_line) == 1)); // R2
      AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (word_line == '0)); // R3
      AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (offset == '0)) |-> word_line[base]); // R6
    end
  endgenerate

endmodule

bind sum_addr_decoder sad_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .base      (base),
  .offset    (offset),
  .word_line (word_line)
);

// File: tb/sum_addr_decoder_bench.sv
module sum_addr_decoder_bench;

  localparam int AW  = 4;
  localparam int NL  = 2 ** AW;
  localparam int AWC = 3;
  localparam int NLC = 2 ** AWC;

  logic           clk;
  logic           rst_n;
  logic           en_r, en_c;
  logic [AW-1:0]  base_r, off_r;
  logic [AWC-1:0] base_c, off_c;
  logic [NL-1:0]  wl_r;
  logic [NLC-1:0] wl_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sum_addr_decoder #(.ADDR_W(AW), .REG_OUT(1'b1)) u_sum_addr_decoder (
    .clk(clk), .rst_n(rst_n), .enable(en_r), .base(base_r), .offset(off_r), .word_line(wl_r));

  sum_addr_decoder #(.ADDR_W(AWC), .REG_OUT(1'b0)) u_sum_addr_decoder_comb (
    .clk(clk), .rst_n(rst_n), .enable(en_c), .base(base_c), .offset(off_c), .word_line(wl_c));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input int a, input int b, input int n, input string base_tag);
    if (a + b >= n) return "R4";
    if (a == 0 || b == 0) return "R6";
    return base_tag;
  endfunction

  // Registered instance: drive at negedge, result visible after next posedge.
  task automatic apply_r(input int a, input int b, input bit e, output logic [NL-1:0] got);
    @(negedge clk);
    base_r = AW'(a);
    off_r  = AW'(b);
    en_r   = e;
    @(negedge clk);
    got = wl_r;
  endtask

  task automatic apply_c(input int a, input int b, input bit e, output logic [NLC-1:0] got);
    @(negedge clk);
    base_c = AWC'(a);
    off_c  = AWC'(b);
    en_c   = e;
    #3;
    got = wl_c;
  endtask

  initial begin
    logic [NL-1:0]  g, g2, prev;
    logic [NLC-1:0] gc;
    rst_n = 1'b0; en_r = 1'b1; en_c = 1'b0;
    base_r = '0; off_r = '0; base_c = '0; off_c = '0;
    repeat (3) @(posedge clk);
    #3;
    check("R5 in reset", wl_r, '0);
    @(negedge clk);
    base_r = 4'd5; off_r = 4'd6;
    rst_n = 1'b1;
    #3;
    check("R5 after release before capture", wl_r, '0);
    @(negedge clk);
    check("R1 first capture", wl_r, NL'(1) << 11);

    // Exhaustive registered sweep
    for (int a = 0; a < NL; a++) begin
      for (int b = 0; b < NL; b++) begin
        apply_r(a, b, 1'b1, g);
        check(tag_for(a, b, NL, "R1"), g, NL'(1) << ((a + b) % NL));
        checks++;
        if ($countones(g) != 1) begin
          fails++;
          $display("FAIL R2: actual %0d lines expected 1", $countones(g));
        end
      end
    end

    // Latency: new operands must not show before the capturing edge
    apply_r(1, 2, 1'b1, prev);
    @(negedge clk);
    base_r = 4'd9; off_r = 4'd9;
    #3;
    check("R1 holds until capture", wl_r, prev);
    @(negedge clk);
    check("R4 wrap 9+9", wl_r, NL'(1) << 2);

    // Commutativity
    for (int a = 0; a < NL; a += 3) begin
      for (int b = 1; b < NL; b += 5) begin
        apply_r(a, b, 1'b1, g);
        apply_r(b, a, 1'b1, g2);
        check("R7 swap", g2, g);
      end
    end

    // Enable low, then recovery
    for (int a = 0; a < NL; a += 4) begin
      apply_r(a, 15 - a, 1'b0, g);
      check("R3 disabled", g, '0);
    end
    apply_r(15, 15, 1'b0, g);
    check("R3 disabled max", g, '0);
    apply_r(15, 15, 1'b1, g);
    check("R4 15+15", g, NL'(1) << 14);

    // Combinational instance exhaustive
    for (int a = 0; a < NLC; a++) begin
      for (int b = 0; b < NLC; b++) begin
        apply_c(a, b, 1'b1, gc);
        check({"R8 ", tag_for(a, b, NLC, "R1")}, NL'(gc), NL'(NLC'(1) << ((a + b) % NLC)));
      end
    end
    for (int a = 0; a < NLC; a++) begin
      apply_c(a, 7 - a, 1'b0, gc);
      check("R8 R3 comb disabled", NL'(gc), '0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule